// File: doc/BRIEF.md
# Dual-Port Address Remap Unit

This block rewrites the addresses issued by a processor on its instruction-fetch port and on its data-access port. Both ports are translated at the same moment. They look up one shared table of remap regions, so one programmed region can serve fetches, loads and stores together. Each region is a pair of 32-bit words. The match word describes a naturally aligned power-of-two window. The remap word carries the replacement base and two per-port enable flags in its two lowest bits.

Software fills the table through a one-word register port. The port has a write strobe, a word selector, write data and a combinational read-back. Translation is purely combinational on each port. A region is compared only on the ports whose enable flag is set. When several enabled regions cover an address, the lowest-numbered one decides the result. An address that no enabled region covers passes through untouched. There is no state machine: the only state is the register table, which is either held or overwritten by one word per cycle.

Top module: `dual_addr_remap`

## Requirements
- R1: The table holds 32 regions shared by both ports. Selector value s addresses region s[5:1]: s[0]=0 selects its match word and s[0]=1 its remap word. A write stores the full 32-bit data, and cfg_rdata_o returns the word at the current selector.
- R2: Reset clears every match and remap word to zero. After reset both ports return their input address unchanged.
- R3: A match word with k trailing one bits (bit k is zero) describes a window of 2^(k+1) bytes. An address hits when its bits 31..k+1 equal the same bits of the match word.
- R4: On a hit, output bits 31..k+1 come from the remap base. The base is the remap word with bits 1:0 forced to zero. Output bits k..0 come from the incoming address.
- R5: Remap bit 0 enables the region for the fetch port and remap bit 1 enables it for the data port. A region whose flag for a port is clear never changes that port's address.
- R6: When several enabled regions hit the same address, the lowest-numbered region supplies the translation.
- R7: When no enabled region hits, the output equals the input.
- R8: Translation is combinational. A register write changes the translation from the clock edge that stores it, and the table holds its contents in cycles without a write.
- R9: The two ports are translated independently and at the same time. The same address can be translated differently on each port according to the per-port flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 6 | Word selector: region index in bits 5:1, match/remap choice in bit 0 |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read-back of the selected word |
| fetch_addr_i | input | 32 | Instruction-fetch address in |
| fetch_addr_o | output | 32 | Translated instruction-fetch address |
| data_addr_i | input | 32 | Data-access address in |
| data_addr_o | output | 32 | Translated data-access address |

## Verification
The bench drives addresses inside a window, at its last byte, and just beyond it. This separates the compare mask from the offset pass-through. A one-bit window checks that the smallest size keeps exactly one offset bit. Two overlapping enabled windows test the priority order, and disabling the winner then shows the other region taking over. Remap words with only the fetch flag, only the data flag, and both flags are each applied while the same address sits on both ports. This shows that the two flags act separately on each port and do not leak across. The outputs are also sampled in the cycle a write is presented and again after it is stored, which pins down the timing of a write.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int unsigned REMAP_ADDR_W = 32;
    localparam int unsigned FETCH_EN_BIT = 0;
    localparam int unsigned DATA_EN_BIT  = 1;

    typedef logic [REMAP_ADDR_W-1:0] addr_t;

    // Bits set in the result are the ones compared; the trailing ones
    // plus the first zero above them form the offset field.
    function automatic addr_t napot_cmp_mask(addr_t match_word);
        return ~(match_word ^ (match_word + addr_t'(1)));
    endfunction

    // Low two bits of the remap word are flags, never address.
    function automatic addr_t remap_base(addr_t remap_word);
        return remap_word & ~addr_t'(3);
    endfunction

endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
    import remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 32,
    localparam int unsigned NWORDS = 2 * NUM_REGIONS,
    localparam int unsigned SEL_W = $clog2(NWORDS)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_i,
    input  logic [SEL_W-1:0]          sel_i,
    input  addr_t                     wdata_i,
    output addr_t                     rdata_o,
    output addr_t [NUM_REGIONS-1:0]   match_o,
    output addr_t [NUM_REGIONS-1:0]   remap_o
);

    addr_t [NWORDS-1:0] word_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_q <= '0;
        end else if (wr_i) begin
            word_q[sel_i] <= wdata_i;
        end
    end

    assign rdata_o = word_q[sel_i];

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_split
        assign match_o[r] = word_q[2*r];
        assign remap_o[r] = word_q[2*r+1];
    end

    AST_CFG_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (word_q[$past(sel_i)] == $past(wdata_i))) else $error("cfg write lost"); // R1

    AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(word_q)) else $error("cfg changed without write"); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (word_q == '0)) else $error("cfg not cleared"); // R2

endmodule

// File: rtl/remap_region_cmp.sv
module remap_region_cmp
    import remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 32,
    parameter int unsigned EN_BIT = FETCH_EN_BIT
) (
    input  addr_t [NUM_REGIONS-1:0] match_i,
    input  addr_t [NUM_REGIONS-1:0] remap_i,
    input  addr_t                   addr_i,
    output logic  [NUM_REGIONS-1:0] hit_o,
    output addr_t [NUM_REGIONS-1:0] cand_o
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        addr_t cmp_mask;
        addr_t base;
        assign cmp_mask = napot_cmp_mask(match_i[r]);
        assign base     = remap_base(remap_i[r]);
        assign hit_o[r] = remap_i[r][EN_BIT]
                          && (((addr_i ^ match_i[r]) & cmp_mask) == '0);
        assign cand_o[r] = (base & cmp_mask) | (addr_i & ~cmp_mask);
    end

endmodule

// File: rtl/remap_port_sel.sv
module remap_port_sel
    import remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 32
) (
    input  logic  [NUM_REGIONS-1:0] hit_i,
    input  addr_t [NUM_REGIONS-1:0] cand_i,
    input  addr_t                   addr_i,
    output addr_t                   addr_o
);

    // Walk from the top down so the lowest hitting index is assigned last.
    always_comb begin
        addr_o = addr_i;
        for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
            if (hit_i[r]) begin
                addr_o = cand_i[r];
            end
        end
    end

endmodule

// File: rtl/dual_addr_remap.sv
module dual_addr_remap
    import remap_pkg::*;
#(
    parameter int unsigned NUM_REGIONS = 32,
    localparam int unsigned SEL_W = $clog2(2 * NUM_REGIONS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [SEL_W-1:0] cfg_sel_i,
    input  logic [31:0]      cfg_wdata_i,
    output logic [31:0]      cfg_rdata_o,
    input  logic [31:0]      fetch_addr_i,
    output logic [31:0]      fetch_addr_o,
    input  logic [31:0]      data_addr_i,
    output logic [31:0]      data_addr_o
);

    localparam int unsigned NUM_PORTS = 2;

    addr_t [NUM_REGIONS-1:0] match_w;
    addr_t [NUM_REGIONS-1:0] remap_w;
    addr_t                   port_in  [NUM_PORTS];
    addr_t                   port_out [NUM_PORTS];

    remap_cfg_regs #(.NUM_REGIONS(NUM_REGIONS)) u_cfg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (cfg_wr_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .rdata_o (cfg_rdata_o),
        .match_o (match_w),
        .remap_o (remap_w)
    );

    assign port_in[0]   = fetch_addr_i;
    assign port_in[1]   = data_addr_i;
    assign fetch_addr_o = port_out[0];
    assign data_addr_o  = port_out[1];

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam int unsigned EN_BIT = (p == 0) ? FETCH_EN_BIT : DATA_EN_BIT;

        logic  [NUM_REGIONS-1:0] hit;
        addr_t [NUM_REGIONS-1:0] cand;
        logic  [NUM_REGIONS-1:0] en_vec;

        for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_en
            assign en_vec[r] = remap_w[r][EN_BIT];
        end

        remap_region_cmp #(.NUM_REGIONS(NUM_REGIONS), .EN_BIT(EN_BIT)) u_cmp (
            .match_i (match_w),
            .remap_i (remap_w),
            .addr_i  (port_in[p]),
            .hit_o   (hit),
            .cand_o  (cand)
        );

        remap_port_sel #(.NUM_REGIONS(NUM_REGIONS)) u_sel (
            .hit_i  (hit),
            .cand_i (cand),
            .addr_i (port_in[p]),
            .addr_o (port_out[p])
        );

        AST_PORT_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_vec == '0) |-> (port_out[p] == port_in[p])) else $error("disabled port translated"); // R5

        AST_MISS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit == '0) |-> (port_out[p] == port_in[p])) else $error("miss altered address"); // R7

        AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
            hit[0] |-> (port_out[p] == cand[0])) else $error("region 0 lost priority"); // R6
    end

endmodule

// File: tb/dual_addr_remap_test.sv
module dual_addr_remap_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [31:0] f_in = '0;
    logic [31:0] f_out;
    logic [31:0] d_in = '0;
    logic [31:0] d_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_addr_remap uut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .cfg_wr_i     (cfg_wr),
        .cfg_sel_i    (cfg_sel),
        .cfg_wdata_i  (cfg_wdata),
        .cfg_rdata_o  (cfg_rdata),
        .fetch_addr_i (f_in),
        .fetch_addr_o (f_out),
        .data_addr_i  (d_in),
        .data_addr_o  (d_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [5:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic set_addr(input logic [31:0] fa, input logic [31:0] da);
        @(negedge clk);
        f_in = fa; d_in = da;
        #1;
    endtask

    task automatic read_word(input logic [5:0] sel, output logic [31:0] val);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        val = cfg_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        read_word(6'd0, v);  check("R2 match0 reset", v, 32'h0);
        read_word(6'd63, v); check("R2 remap31 reset", v, 32'h0);
        set_addr(32'h0000_0000, 32'h0000_0001);
        check("R2 fetch passthru", f_out, 32'h0000_0000);
        check("R2 data passthru", d_out, 32'h0000_0001);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        write_word(6'd63, 32'hDEAD_BEE0);
        read_word(6'd63, v); check("R1 remap31 readback", v, 32'hDEAD_BEE0);
        write_word(6'd62, 32'h1234_5677);
        read_word(6'd62, v); check("R1 match31 readback", v, 32'h1234_5677);
        read_word(6'd63, v); check("R1 neighbour intact", v, 32'hDEAD_BEE0);
    endtask

    task automatic t_basic;
        // 8 KiB window at 0x2000_0000, both ports enabled
        write_word(6'd0, 32'h2000_0FFF);
        set_addr(32'h2000_1234, 32'h2000_1FFC);
        check("R7 before enable fetch", f_out, 32'h2000_1234);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 6'd1; cfg_wdata = 32'h8000_0003;
        #1;
        check("R8 not yet stored", f_out, 32'h2000_1234);
        @(posedge clk); #1;
        cfg_wr = 1'b0;
        check("R8 stored at edge", f_out, 32'h8000_1234);
        check("R4 data last byte", d_out, 32'h8000_1FFC);
        set_addr(32'h2000_2000, 32'h1FFF_FFFC);
        check("R3 above window", f_out, 32'h2000_2000);
        check("R3 below window", d_out, 32'h1FFF_FFFC);
    endtask

    task automatic t_enables;
        write_word(6'd1, 32'h8000_0001);
        set_addr(32'h2000_0040, 32'h2000_0040);
        check("R5 fetch only: fetch", f_out, 32'h8000_0040);
        check("R5 fetch only: data", d_out, 32'h2000_0040);
        write_word(6'd1, 32'h8000_0002);
        #1;
        check("R5 data only: fetch", f_out, 32'h2000_0040);
        check("R5 data only: data", d_out, 32'h8000_0040);
    endtask

    task automatic t_priority;
        write_word(6'd1, 32'h8000_0003);
        write_word(6'd10, 32'h2000_01FF);  // region 5, 1 KiB
        write_word(6'd11, 32'h4000_0003);
        set_addr(32'h2000_0100, 32'h2000_0100);
        check("R6 region0 wins", f_out, 32'h8000_0100);
        write_word(6'd1, 32'h8000_0000);
        #1;
        check("R6 region5 after disable", d_out, 32'h4000_0100);
        write_word(6'd1, 32'h8000_0001);
        #1;
        check("R9 fetch via region0", f_out, 32'h8000_0100);
        check("R9 data via region5", d_out, 32'h4000_0100);
    endtask

    task automatic t_smallest;
        write_word(6'd1, 32'h0);
        write_word(6'd11, 32'h0);
        write_word(6'd20, 32'h3000_0004);  // region 10, 2-byte window
        write_word(6'd21, 32'h5000_0003);
        set_addr(32'h3000_0004, 32'h3000_0005);
        check("R3 two-byte low", f_out, 32'h5000_0000);
        check("R4 two-byte offset bit", d_out, 32'h5000_0001);
        set_addr(32'h3000_0006, 32'h3000_0006);
        check("R3 two-byte miss", f_out, 32'h3000_0006);
        check("R7 two-byte miss data", d_out, 32'h3000_0006);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_basic();
        t_enables();
        t_priority();
        t_smallest();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule